// File: doc/BRIEF.md
# Camera Sample Word Packer

This block sits between a camera-side receiver and a 32-bit capture FIFO. Each clock, the receiver may present one sample on a 16-bit bus, qualified by a valid strobe. The block gathers consecutive samples into 32-bit words and hands them on through a valid/ready output stream. A mode input picks one of two packings. Narrow packing keeps one 8-bit field from every sample and needs four samples per word. For YUV 4:2:2 this means one pixel arrives over two samples. Wide packing keeps the whole 16-bit sample and needs two samples per word, so one pixel arrives per sample.

A frame-start marker goes with the first sample of each frame. It throws away any word that is only partly built and re-reads the mode input, so the packing always starts clean at the lowest lane. Backpressure from the FIFO side stops intake instead of losing data. While a finished word waits, the input ready signal stays low.

Top module: `cam_word_packer`

## Requirements
- R1: With mode at 0 (narrow), each accepted sample contributes input bits [9:2] as one byte, and four accepted samples form one output word.
- R2: With mode at 1 (wide), each accepted sample contributes all 16 input bits, and two accepted samples form one output word.
- R3: The first sample of a word occupies the lowest lane (bits [7:0] narrow, [15:0] wide), and each later sample fills the next higher lane.
- R4: A frame-start taken while input ready is high discards any partly built word. A sample accepted together with it lands in lane 0.
- R5: The mode input is read at each accepted frame-start and before the first sample after reset. A change in the middle of a frame is ignored until the next frame-start.
- R6: While an output word is valid and not ready, the word and its valid stay unchanged and input ready is low. Each completed word is delivered exactly once, and no sample is lost or repeated.
- R7: Reset clears output valid, raises input ready, and leaves no partial word, so the next word is built only from samples accepted after reset.
- R8: Output valid rises in the cycle right after the sample that completes a word is accepted.
- R9: Idle cycles (valid low) between samples do not change which lane the next sample fills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide_i | input | 1 | Packing select: 0 narrow (4 bytes per word), 1 wide (2 halves per word) |
| sof_i | input | 1 | Frame-start marker, sideband of the current sample |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 16 | Input sample bus |
| in_ready_o | output | 1 | Block can take a sample this cycle |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Packed output word |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The assertions check on every cycle that a stalled word holds steady, that the lane counter stays inside the range of the active mode, that a frame-start resets the counter to the right lane, and that output valid only rises after an accepted sample. Lane placement, which bus bits are picked, whether the mode input is ignored in the middle of a frame, and exactly-once delivery across a stall can only be shown by the bench's scenarios. They compare the sequence of words seen at the output with the words built from the samples that were driven.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
   typedef enum logic {
      PACK_NARROW = 1'b0,
      PACK_WIDE   = 1'b1
   } pack_mode_e;
endpackage

// File: rtl/cwp_sample_slicer.sv
module cwp_sample_slicer #(
   parameter int IN_W       = 16,
   parameter int SEG_W      = 8,
   parameter int NARROW_LSB = 2
) (
   input  logic [IN_W-1:0]  data_i,
   output logic [SEG_W-1:0] narrow_o
);
   generate
      if (NARROW_LSB + SEG_W > IN_W) begin : g_bad_slice
         $error("narrow field does not fit in the input bus");
      end
      if (NARROW_LSB == 0) begin : g_low
         assign narrow_o = data_i[SEG_W-1:0];
      end else begin : g_offset
         assign narrow_o = data_i[NARROW_LSB +: SEG_W];
      end
   endgenerate
endmodule

// File: rtl/cwp_lane_ctrl.sv
module cwp_lane_ctrl
   import cwp_pkg::*;
#(
   parameter int NARROW_LANES = 4,
   parameter int WIDE_LANES   = 2,
   parameter int CNT_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pack_mode_e       mode_i,
   input  logic             sof_i,
   input  logic             ready_i,
   input  logic             take_i,
   output pack_mode_e       mode_o,
   output logic [CNT_W-1:0] lane_o,
   output logic             last_o
);
   logic             started_q;
   pack_mode_e       mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sof_take;
   logic             load_mode;

   assign sof_take  = sof_i && ready_i;
   assign load_mode = sof_take || !started_q;
   assign mode_o    = load_mode ? mode_i : mode_q;
   assign lane_o    = sof_take ? '0 : cnt_q;
   assign last_o    = (mode_o == PACK_WIDE) ? (lane_o == CNT_W'(WIDE_LANES - 1))
                                            : (lane_o == CNT_W'(NARROW_LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         mode_q    <= PACK_NARROW;
         cnt_q     <= '0;
      end else begin
         if (load_mode) mode_q <= mode_i;
         if (take_i || sof_take) started_q <= 1'b1;
         if (take_i) cnt_q <= last_o ? '0 : lane_o + CNT_W'(1);
         else if (sof_take) cnt_q <= '0;
      end
   end

   AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == PACK_WIDE) |-> (cnt_q < CNT_W'(WIDE_LANES))); // R2
   AST_SOF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_take && !take_i) |=> (cnt_q == '0)); // R4
   AST_SOF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_take && take_i) |=> (cnt_q == CNT_W'(1))); // R4
endmodule

// File: rtl/cwp_word_assembler.sv
module cwp_word_assembler
   import cwp_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int OUT_W      = 32,
   parameter int SEG_W      = 8,
   parameter int NARROW_LSB = 2,
   parameter int CNT_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             last_i,
   input  pack_mode_e       mode_i,
   input  logic [CNT_W-1:0] lane_i,
   input  logic [IN_W-1:0]  data_i,
   input  logic             out_ready_i,
   output logic             in_ready_o,
   output logic             out_valid_o,
   output logic [OUT_W-1:0] out_data_o
);
   localparam int LANES     = OUT_W / SEG_W;
   localparam int WIDE_SEGS = IN_W / SEG_W;

   logic [SEG_W-1:0] narrow_seg;
   logic [OUT_W-1:0] merged;
   logic             out_valid_q;
   logic [OUT_W-1:0] out_data_q;

   cwp_sample_slicer #(
      .IN_W(IN_W), .SEG_W(SEG_W), .NARROW_LSB(NARROW_LSB)
   ) u_slicer (
      .data_i  (data_i),
      .narrow_o(narrow_seg)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int WORD_IX = l / WIDE_SEGS;
      localparam int PART    = l % WIDE_SEGS;
      logic [SEG_W-1:0] acc_q;
      logic [SEG_W-1:0] seg;
      logic             hit;

      assign hit = (mode_i == PACK_WIDE) ? (lane_i == CNT_W'(WORD_IX))
                                         : (lane_i == CNT_W'(l));
      assign seg = (mode_i == PACK_WIDE) ? data_i[PART*SEG_W +: SEG_W] : narrow_seg;
      assign merged[l*SEG_W +: SEG_W] = (take_i && hit) ? seg : acc_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) acc_q <= '0;
         else if (take_i && hit) acc_q <= seg;
      end
   end

   assign in_ready_o  = !out_valid_q || out_ready_i;
   assign out_valid_o = out_valid_q;
   assign out_data_o  = out_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
      end else if (take_i && last_i) begin
         out_valid_q <= 1'b1;
         out_data_q  <= merged;
      end else if (out_ready_i) begin
         out_valid_q <= 1'b0;
      end
   end

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_q && !out_ready_i) |=> (out_valid_q && $stable(out_data_q))); // R6
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
   import cwp_pkg::*;
#(
   parameter int IN_W       = 16,
   parameter int OUT_W      = 32,
   parameter int SEG_W      = 8,
   parameter int NARROW_LSB = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wide_i,
   input  logic             sof_i,
   input  logic             in_valid_i,
   input  logic [IN_W-1:0]  in_data_i,
   output logic             in_ready_o,
   output logic             out_valid_o,
   output logic [OUT_W-1:0] out_data_o,
   input  logic             out_ready_i
);
   localparam int NARROW_LANES = OUT_W / SEG_W;
   localparam int WIDE_LANES   = OUT_W / IN_W;
   localparam int CNT_W        = (NARROW_LANES > 1) ? $clog2(NARROW_LANES) : 1;

   generate
      if (OUT_W % IN_W != 0 || IN_W % SEG_W != 0) begin : g_bad_ratio
         $error("widths must divide evenly");
      end
      if (WIDE_LANES < 2) begin : g_bad_wide
         $error("output word must hold at least two wide samples");
      end
   endgenerate

   pack_mode_e       mode_req;
   pack_mode_e       mode_act;
   logic [CNT_W-1:0] lane;
   logic             last;
   logic             take;
   logic             ready;

   assign mode_req   = mode_wide_i ? PACK_WIDE : PACK_NARROW;
   assign take       = in_valid_i && ready;
   assign in_ready_o = ready;

   cwp_lane_ctrl #(
      .NARROW_LANES(NARROW_LANES), .WIDE_LANES(WIDE_LANES), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_req),
      .sof_i  (sof_i),
      .ready_i(ready),
      .take_i (take),
      .mode_o (mode_act),
      .lane_o (lane),
      .last_o (last)
   );

   cwp_word_assembler #(
      .IN_W(IN_W), .OUT_W(OUT_W), .SEG_W(SEG_W), .NARROW_LSB(NARROW_LSB), .CNT_W(CNT_W)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .last_i     (last),
      .mode_i     (mode_act),
      .lane_i     (lane),
      .data_i     (in_data_i),
      .out_ready_i(out_ready_i),
      .in_ready_o (ready),
      .out_valid_o(out_valid_o),
      .out_data_o (out_data_o)
   );

   AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o)); // R8
   AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |-> !in_ready_o); // R6
endmodule

// File: tb/cam_word_packer_bench.sv
module cam_word_packer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wide = 1'b0;
   logic        sof = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [31:0] got_q[$];
   logic [31:0] exp_q[$];

   always #10 clk = ~clk;

   cam_word_packer u_cam_word_packer (
      .clk(clk), .rst_n(rst_n), .mode_wide_i(mode_wide), .sof_i(sof),
      .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
      .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
   );

   // capture every handshake just before the edge that completes it
   always @(negedge clk) begin
      #9;
      if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // narrow sample: useful byte at [9:2], filler elsewhere
   function automatic logic [15:0] nsm(input logic [7:0] b, input logic [7:0] g);
      return {g[5:0], b, g[7:6]};
   endfunction

   task automatic put(input logic [15:0] d, input logic s);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; sof = s;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      in_valid = 1'b0; sof = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic compare(input string req);
      idle(3);
      chk(req, "word count", 32'(got_q.size()), 32'(exp_q.size()));
      foreach (exp_q[i]) begin
         if (i < got_q.size()) chk(req, "word", got_q[i], exp_q[i]);
      end
      got_q.delete(); exp_q.delete();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; sof = 1'b0;
      idle(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk("R7", "out_valid after reset", 32'(out_valid), 32'd0);
      chk("R7", "in_ready after reset", 32'(in_ready), 32'd1);
   endtask

   task automatic t_narrow();
      mode_wide = 1'b0;
      put(nsm(8'h11, 8'hFF), 1'b1);
      put(nsm(8'h22, 8'h00), 1'b0);
      put(nsm(8'h33, 8'hA5), 1'b0);
      #1 chk("R8", "valid low before last sample", 32'(out_valid), 32'd0);
      put(nsm(8'h44, 8'h5A), 1'b0);
      chk("R8", "valid right after last sample", 32'(out_valid), 32'd1);
      chk("R1", "narrow word", out_data, 32'h44332211);
      exp_q.push_back(32'h44332211);
      put(nsm(8'hDE, 8'h3C), 1'b0);
      put(nsm(8'hAD, 8'hC3), 1'b0);
      put(nsm(8'hBE, 8'h0F), 1'b0);
      put(nsm(8'hEF, 8'hF0), 1'b0);
      exp_q.push_back(32'hEFBEADDE);
      compare("R3");
   endtask

   task automatic t_wide();
      mode_wide = 1'b1;
      put(16'h1234, 1'b1);
      put(16'h5678, 1'b0);
      put(16'h9ABC, 1'b0);
      put(16'hDEF0, 1'b0);
      exp_q.push_back(32'h56781234);
      exp_q.push_back(32'hDEF09ABC);
      compare("R2");
   endtask

   task automatic t_sof_restart();
      mode_wide = 1'b0;
      put(nsm(8'hA1, 8'h77), 1'b1);
      put(nsm(8'hA2, 8'h77), 1'b0);
      put(nsm(8'hB1, 8'h12), 1'b1);
      put(nsm(8'hB2, 8'h34), 1'b0);
      put(nsm(8'hB3, 8'h56), 1'b0);
      put(nsm(8'hB4, 8'h78), 1'b0);
      exp_q.push_back(32'hB4B3B2B1);
      compare("R4");
   endtask

   task automatic t_mode_midframe();
      mode_wide = 1'b0;
      put(nsm(8'hC0, 8'h99), 1'b1);
      put(nsm(8'hC1, 8'h99), 1'b0);
      mode_wide = 1'b1;
      put(nsm(8'hC2, 8'h66), 1'b0);
      put(nsm(8'hC3, 8'h66), 1'b0);
      exp_q.push_back(32'hC3C2C1C0);
      put(16'hAAAA, 1'b1);
      put(16'h5555, 1'b0);
      exp_q.push_back(32'h5555AAAA);
      compare("R5");
   endtask

   task automatic t_backpressure();
      logic [31:0] held;
      mode_wide = 1'b1;
      out_ready = 1'b0;
      put(16'h0102, 1'b1);
      put(16'h0304, 1'b0);
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'h0506;
      #1;
      chk("R6", "in_ready low in stall", 32'(in_ready), 32'd0);
      held = out_data;
      chk("R6", "stalled word", held, 32'h03040102);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk("R6", "valid held", 32'(out_valid), 32'd1);
         chk("R6", "data held", out_data, held);
      end
      out_ready = 1'b1;
      #1;
      chk("R6", "in_ready after release", 32'(in_ready), 32'd1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      put(16'h0708, 1'b0);
      exp_q.push_back(32'h03040102);
      exp_q.push_back(32'h07080506);
      compare("R6");
   endtask

   task automatic t_gaps();
      mode_wide = 1'b0;
      put(nsm(8'h01, 8'h00), 1'b1);
      idle(2);
      put(nsm(8'h02, 8'hFF), 1'b0);
      idle(5);
      put(nsm(8'h03, 8'h00), 1'b0);
      idle(1);
      put(nsm(8'h04, 8'hFF), 1'b0);
      exp_q.push_back(32'h04030201);
      compare("R9");
   endtask

   task automatic t_reset_partial();
      mode_wide = 1'b0;
      put(nsm(8'hEE, 8'h00), 1'b1);
      put(nsm(8'hEE, 8'h00), 1'b0);
      do_reset();
      #1 chk("R7", "no word after mid-word reset", 32'(out_valid), 32'd0);
      mode_wide = 1'b1;
      put(16'h4321, 1'b0);
      put(16'h8765, 1'b0);
      exp_q.push_back(32'h87654321);
      compare("R7");
   endtask

   initial begin
      t_reset();
      t_narrow();
      t_wide();
      t_sof_restart();
      t_mode_midframe();
      t_backpressure();
      t_gaps();
      t_reset_partial();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule